// File: doc/BRIEF.md
# Keypad Interrupt and Key Mask Controller

This block keeps a record of which of sixteen keys are held down and drives an active-low interrupt line to a host processor. A separate event port reports each key press and each key release. A mask register hides individual keys. Only keys that the mask leaves visible can raise the interrupt, and only those keys show in the key-data readout.

The host reaches the block through a small register port that has four word addresses. A pending interrupt can be retired in three ways, and the keypad mode field picks which ones apply. Releasing the last visible key clears it automatically unless mode bit 0 is set. Writing a 1 to the scan bit always clears it. Reading key data clears it when mode bit 1 is set. The debounce field is only stored and read back; no timing hangs on it. Scanning of the physical key matrix is done elsewhere.

Top module: `kpd_irq_ctrl`

## Requirements
- R1: After synchronous reset, `kbd_irq_n` is 1, the key bitmap, mask, mode, scan and debounce are all 0, and a status read at address 0 returns 0x4000.
- R2: A key event with `key_evt_press`=1 sets bit `key_evt_idx` of the bitmap, and one with `key_evt_press`=0 clears it. The new bitmap is visible from the cycle after the event.
- R3: When no interrupt is pending and a press leaves at least one unmasked key down, the interrupt becomes pending. `kbd_irq_n` goes low after the clock edge that takes the event.
- R4: While pending, any key event that leaves no unmasked key down clears the interrupt (`kbd_irq_n` returns to 1) when mode bit 0 is 0. When mode bit 0 is 1, the interrupt stays pending.
- R5: A write to address 0 stores the scan bit from bit 14 and the 3-bit debounce field from bits 13:11. If bit 14 is 1 while an interrupt is pending, the interrupt is cleared.
- R6: A read of address 0 returns the pending flag in bit 15, (scan OR no key down) in bit 14, debounce in bits 13:11, and 0 elsewhere.
- R7: A write to address 1 stores the 2-bit mode from bits 15:14. A read of address 1 returns the inverse of `dav_in` in bit 15, mode bit 0 in bit 14, and 0 elsewhere.
- R8: A read of address 2 while pending clears the interrupt when mode bit 1 is 1, and leaves it pending when mode bit 1 is 0.
- R9: A read of address 2 returns the bitmap with masked keys forced to 0, bit n standing for key n. Writes to address 2 have no effect.
- R10: Address 3 holds a 16-bit mask (1 = key hidden) that is written and read back whole. A press of a masked key alone does not raise the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| key_evt_valid | input | 1 | A key event is presented this cycle |
| key_evt_idx | input | 4 | Number of the key that changed |
| key_evt_press | input | 1 | 1 = pressed, 0 = released |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from the address |
| dav_in | input | 1 | Data-available flag from the converter side |
| kbd_irq_n | output | 1 | Keypad interrupt, active low |

## Verification
Every state change is due one clock edge after its stimulus. A key event, a scan write or a key-data read takes effect at the edge that samples it. `kbd_irq_n` and the bitmap change right after that edge, and `reg_rdata` shows the stored state in the same cycle as the address, because no register sits in the read path. The bench drives every stimulus on a falling edge and removes it on the next falling edge. It checks the line after that edge, and it captures read data in the middle of the read's own cycle. So the value before a read's side effect is caught first, and the value after it is checked in the cycle that follows.

// File: rtl/kpd_pkg.sv
// Package for the keypad interrupt controller: the register address
// encodings and the bit positions of the fields that the host decodes.
// Assumes that register words are 16 bits wide.
package kpd_pkg;
    typedef enum logic [1:0] {
        KPD_A_STATUS = 2'd0,
        KPD_A_CFG2   = 2'd1,
        KPD_A_KDATA  = 2'd2,
        KPD_A_MASK   = 2'd3
    } kpd_addr_e;

    localparam int KPD_PEND_BIT = 15;
    localparam int KPD_SCAN_BIT = 14;
    localparam int KPD_DEB_HI   = 13;
    localparam int KPD_DEB_LO   = 11;
    localparam int KPD_DEB_W    = KPD_DEB_HI - KPD_DEB_LO + 1;
    localparam int KPD_MODE_HI  = 15;
    localparam int KPD_MODE_LO  = 14;
    localparam int KPD_MODE_W   = KPD_MODE_HI - KPD_MODE_LO + 1;
    localparam int KPD_DAVN_BIT = 15;
    localparam int KPD_M0_BIT   = 14;
endpackage

// File: rtl/kpd_key_map.sv
// Pressed-key bitmap. There is one flop per key, set by a press event and
// cleared by a release event for that key. It also gives the value the
// bitmap takes after the current event, which the interrupt logic needs.
// Assumes at most one key event per cycle.
module kpd_key_map #(
    parameter int NUM_KEYS  = 16,
    parameter int KEY_IDX_W = $clog2(NUM_KEYS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_valid,
    input  logic [KEY_IDX_W-1:0] evt_idx,
    input  logic                 evt_press,
    output logic [NUM_KEYS-1:0]  down,
    output logic [NUM_KEYS-1:0]  next_down
);
    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
        logic hit;
        // Decode whether this event targets key k.
        assign hit = evt_valid && (evt_idx == KEY_IDX_W'(k));
        // Bitmap value after this cycle's event.
        assign next_down[k] = hit ? evt_press : down[k];
        // Hold one key's pressed state.
        always_ff @(posedge clk) begin
            if (!rst_n) down[k] <= 1'b0;
            else        down[k] <= next_down[k];
        end
    end

    // R2
    press_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && evt_press |=> down[$past(evt_idx)]);
    // R2
    release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && !evt_press |=> !down[$past(evt_idx)]);
endmodule

// File: rtl/kpd_pend_ctrl.sv
// Interrupt-pending flag. It is set by a press that leaves a visible key down
// while nothing is pending. It is cleared by a key event that leaves no
// visible key down (unless hold mode is on), by a scan write, or by a
// key-data read in read-clear mode. Assumes the request inputs are
// single-cycle strobes.
module kpd_pend_ctrl #(
    parameter int NUM_KEYS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                evt_valid,
    input  logic                evt_press,
    input  logic [NUM_KEYS-1:0] next_down,
    input  logic [NUM_KEYS-1:0] mask,
    input  logic                hold_mode,
    input  logic                rdclr_mode,
    input  logic                scan_req,
    input  logic                kdata_rd,
    output logic                pend
);
    logic any_vis;
    logic set_c;
    logic clr_c;

    // Detect any unmasked key down after this cycle's event.
    assign any_vis = |(next_down & ~mask);

    // Combine the set source and the three clear sources.
    always_comb begin
        set_c = evt_valid && evt_press && any_vis && !pend;
        clr_c = (evt_valid && !any_vis && !hold_mode)
              || scan_req
              || (kdata_rd && rdclr_mode);
    end

    // Pending flag register; a set wins over any clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend <= 1'b0;
        else if (set_c) pend <= 1'b1;
        else if (clr_c) pend <= 1'b0;
    end

    // R3
    raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend && evt_valid && evt_press && |(next_down & ~mask) |=> pend);
    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend && hold_mode && !scan_req && !(kdata_rd && rdclr_mode) |=> pend);
    // R4
    autoclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend && evt_valid && !hold_mode && (next_down & ~mask) == '0 |=> !pend);
    // R5
    scan_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend && scan_req |=> !pend);
    // R8
    rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend && kdata_rd && rdclr_mode |=> !pend);
endmodule

// File: rtl/kpd_regs.sv
// Host register file: status/control, secondary configuration, key data
// and key mask. It decodes the writes, builds the read word and produces
// the access strobes for the pending logic. Assumes at most one access
// (read or write) per cycle.
module kpd_regs
    import kpd_pkg::*;
#(
    parameter int NUM_KEYS = 16,
    parameter int DATA_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic                rd,
    input  logic [1:0]          addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [NUM_KEYS-1:0] down,
    input  logic                pend,
    input  logic                dav,
    output logic [DATA_W-1:0]   rdata,
    output logic [NUM_KEYS-1:0] mask,
    output logic [KPD_MODE_W-1:0] mode,
    output logic                scan_req,
    output logic                kdata_rd
);
    logic                 scan_q;
    logic [KPD_DEB_W-1:0] deb_q;

    // Strobes to the pending logic.
    assign scan_req = wr && (addr == KPD_A_STATUS) && wdata[KPD_SCAN_BIT];
    assign kdata_rd = rd && (addr == KPD_A_KDATA);

    // Status/control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_q <= 1'b0;
            deb_q  <= '0;
        end else if (wr && addr == KPD_A_STATUS) begin
            scan_q <= wdata[KPD_SCAN_BIT];
            deb_q  <= wdata[KPD_DEB_HI:KPD_DEB_LO];
        end
    end

    // Keypad mode field.
    always_ff @(posedge clk) begin
        if (!rst_n)                        mode <= '0;
        else if (wr && addr == KPD_A_CFG2) mode <= wdata[KPD_MODE_HI:KPD_MODE_LO];
    end

    // Key mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)                        mask <= '0;
        else if (wr && addr == KPD_A_MASK) mask <= wdata[NUM_KEYS-1:0];
    end

    // Read-data multiplexer.
    always_comb begin
        rdata = '0;
        unique case (addr)
            KPD_A_STATUS: begin
                rdata[KPD_PEND_BIT]           = pend;
                rdata[KPD_SCAN_BIT]           = scan_q || (down == '0);
                rdata[KPD_DEB_HI:KPD_DEB_LO]  = deb_q;
            end
            KPD_A_CFG2: begin
                rdata[KPD_DAVN_BIT] = !dav;
                rdata[KPD_M0_BIT]   = mode[0];
            end
            KPD_A_KDATA: rdata[NUM_KEYS-1:0] = down & ~mask;
            KPD_A_MASK:  rdata[NUM_KEYS-1:0] = mask;
            default:     rdata = '0;
        endcase
    end

    // R10
    mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr && addr == KPD_A_MASK |=> mask == $past(wdata[NUM_KEYS-1:0]));
    // R7
    mode_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == KPD_A_CFG2) |=> $stable(mode));
endmodule

// File: rtl/kpd_irq_ctrl.sv
// Top level of the keypad interrupt and key mask controller. It ties
// together the key bitmap, the pending-interrupt logic and the register
// file, and drives the active-low interrupt line from the pending flop.
// Assumes the key events and the register accesses are synchronous to clk.
module kpd_irq_ctrl
    import kpd_pkg::*;
#(
    parameter int NUM_KEYS  = 16,
    parameter int DATA_W    = 16,
    parameter int KEY_IDX_W = $clog2(NUM_KEYS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 key_evt_valid,
    input  logic [KEY_IDX_W-1:0] key_evt_idx,
    input  logic                 key_evt_press,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [1:0]           reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic                 dav_in,
    output logic                 kbd_irq_n
);
    logic [NUM_KEYS-1:0]   down;
    logic [NUM_KEYS-1:0]   next_down;
    logic [NUM_KEYS-1:0]   mask;
    logic [KPD_MODE_W-1:0] mode;
    logic                  scan_req;
    logic                  kdata_rd;
    logic                  pend;

    kpd_key_map #(.NUM_KEYS(NUM_KEYS), .KEY_IDX_W(KEY_IDX_W)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (key_evt_valid),
        .evt_idx   (key_evt_idx),
        .evt_press (key_evt_press),
        .down      (down),
        .next_down (next_down)
    );

    kpd_pend_ctrl #(.NUM_KEYS(NUM_KEYS)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_valid  (key_evt_valid),
        .evt_press  (key_evt_press),
        .next_down  (next_down),
        .mask       (mask),
        .hold_mode  (mode[0]),
        .rdclr_mode (mode[1]),
        .scan_req   (scan_req),
        .kdata_rd   (kdata_rd),
        .pend       (pend)
    );

    kpd_regs #(.NUM_KEYS(NUM_KEYS), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .rd       (reg_rd),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .down     (down),
        .pend     (pend),
        .dav      (dav_in),
        .rdata    (reg_rdata),
        .mask     (mask),
        .mode     (mode),
        .scan_req (scan_req),
        .kdata_rd (kdata_rd)
    );

    // Active-low interrupt line, driven straight from the pending flop.
    assign kbd_irq_n = !pend;

    // R3
    fall_by_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(kbd_irq_n) |-> $past(key_evt_valid && key_evt_press));
    // R10
    masked_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_irq_n && (next_down & ~mask) == '0 |=> kbd_irq_n);
endmodule

// File: tb/kpd_irq_ctrl_tb_top.sv
// Directed bench for the keypad interrupt controller.
module kpd_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_evt_valid = 1'b0;
    logic [3:0]  key_evt_idx = '0;
    logic        key_evt_press = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        dav_in = 1'b1;
    logic        kbd_irq_n;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kpd_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .key_evt_valid(key_evt_valid), .key_evt_idx(key_evt_idx),
        .key_evt_press(key_evt_press),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dav_in(dav_in), .kbd_irq_n(kbd_irq_n)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
        end
    endtask

    task automatic key(input int idx, input bit press);
        @(negedge clk);
        key_evt_valid = 1'b1; key_evt_idx = 4'(idx); key_evt_press = press;
        @(negedge clk);
        key_evt_valid = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R1 irq idle", 16'(kbd_irq_n), 16'h1);
        rd(2'd0, v); chk("R1 status", v, 16'h4000);
        rd(2'd2, v); chk("R1 keydata", v, 16'h0000);
        rd(2'd3, v); chk("R1 mask", v, 16'h0000);
        rd(2'd1, v); chk("R1 cfg2 dav=1", v, 16'h0000);
    endtask

    task automatic t_bitmap();
        logic [15:0] v;
        key(3, 1);
        chk("R3 irq low after press", 16'(kbd_irq_n), 16'h0);
        rd(2'd2, v); chk("R2 key3 down", v, 16'h0008);
        key(10, 1);
        rd(2'd2, v); chk("R2 keys 3,10", v, 16'h0408);
        key(3, 0);
        rd(2'd2, v); chk("R2 key3 released", v, 16'h0400);
        chk("R4 still pending, key10 down", 16'(kbd_irq_n), 16'h0);
        key(10, 0);
        chk("R4 autoclear on last release", 16'(kbd_irq_n), 16'h1);
    endtask

    task automatic t_hold_scan();
        logic [15:0] v;
        wr(2'd1, 16'h4000);
        key(5, 1);
        chk("R3 raise in hold mode", 16'(kbd_irq_n), 16'h0);
        key(5, 0);
        chk("R4 hold keeps pending", 16'(kbd_irq_n), 16'h0);
        rd(2'd0, v); chk("R6 status pend no keys", v, 16'hC000);
        wr(2'd0, 16'h4000);
        chk("R5 scan write clears", 16'(kbd_irq_n), 16'h1);
        rd(2'd0, v); chk("R6 status scan set", v, 16'h4000);
        wr(2'd0, 16'h2800);
        rd(2'd0, v); chk("R5 debounce stored", v, 16'h6800);
        key(1, 1);
        rd(2'd0, v); chk("R6 status key down", v, 16'hA800);
        key(1, 0);
        rd(2'd0, v); chk("R6 status held pend", v, 16'hE800);
        wr(2'd0, 16'h4000);
        chk("R5 scan clear again", 16'(kbd_irq_n), 16'h1);
    endtask

    task automatic t_cfg2();
        logic [15:0] v;
        dav_in = 1'b0;
        rd(2'd1, v); chk("R7 cfg2 dav=0 mode0=1", v, 16'hC000);
        dav_in = 1'b1;
        rd(2'd1, v); chk("R7 cfg2 dav=1 mode0=1", v, 16'h4000);
        wr(2'd1, 16'h8000);
        rd(2'd1, v); chk("R7 cfg2 mode0=0", v, 16'h0000);
    endtask

    task automatic t_kdata_clear();
        logic [15:0] v;
        wr(2'd1, 16'hC000);
        key(7, 1);
        chk("R3 raise before read", 16'(kbd_irq_n), 16'h0);
        rd(2'd2, v); chk("R9 keydata key7", v, 16'h0080);
        chk("R8 read clears in mode1", 16'(kbd_irq_n), 16'h1);
        key(7, 0);
        wr(2'd1, 16'h4000);
        key(7, 1);
        rd(2'd2, v);
        chk("R8 read no clear without mode1", 16'(kbd_irq_n), 16'h0);
        key(7, 0);
        wr(2'd0, 16'h4000);
        chk("R5 cleanup clear", 16'(kbd_irq_n), 16'h1);
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_mask();
        logic [15:0] v;
        wr(2'd3, 16'h0010);
        rd(2'd3, v); chk("R10 mask readback", v, 16'h0010);
        key(4, 1);
        chk("R10 masked press no irq", 16'(kbd_irq_n), 16'h1);
        rd(2'd2, v); chk("R9 masked key hidden", v, 16'h0000);
        wr(2'd2, 16'h1234);
        rd(2'd2, v); chk("R9 keydata write ignored", v, 16'h0000);
        key(2, 1);
        chk("R3 unmasked press irq", 16'(kbd_irq_n), 16'h0);
        rd(2'd2, v); chk("R9 keydata masked view", v, 16'h0004);
        key(2, 0);
        chk("R4 clear with only masked down", 16'(kbd_irq_n), 16'h1);
        key(4, 0);
        wr(2'd3, 16'hFFFF);
        rd(2'd3, v); chk("R10 mask all ones", v, 16'hFFFF);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bitmap();
        t_hold_scan();
        t_cfg2();
        t_kdata_clear();
        t_mask();
        repeat (2) @(negedge clk);
        report();
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end
endmodule